// File: doc/BRIEF.md
# Unpacked Floating-Point Adder Core

This block adds two floating-point values that an upstream stage has already unpacked into an internal form. Each operand carries a three-bit class code, a sign, a signed unbiased exponent, a mantissa with an explicit integer bit and one guard bit above it, and a separate sticky bit for anything already lost below the mantissa. To subtract, the caller flips the sign of the second operand before presenting it. A rounding-mode field only affects the sign of zero results. Packing into an interchange format, final rounding and input denormal handling happen elsewhere.

The core first ranks the operands by class, so the "heavier" one ends up in the second (y) position. Special classes are then resolved in a fixed order. Two finite numbers are aligned and added. When the signs differ, the core always subtracts y from x and repairs a wrong-order result by negating it when the borrow shows. A result below 1.0 is normalized one bit per clock, and the `done` pulse marks the end of the operation. The result and flags stay on the outputs until the next accepted operation.

Top module: `fadd_core`

## Requirements
- R1: Operands are ranked by class code (zero 0, number 1, infinity 2, quiet NaN 3, signalling NaN 4); the higher code becomes y, so a signalling NaN wins over a quiet NaN whichever port it arrives on.
- R2: When y is a NaN, the result is y with every field unchanged; `inv_snan` is 1 only when that NaN is signalling (code 4).
- R3: When y is infinite and x is an infinity of the other sign, the result is the default quiet NaN (class 3, sign 0, exponent 0, mantissa 0, sticky 0) and `inv_inf` is 1; any other case with infinite y returns y.
- R4: When both operands are zero, the result is y with its sign replaced by the AND of both signs, or by the OR when `rnd_mode` is 2'b11 (toward minus infinity).
- R5: When only one operand is zero, the result is the other operand with all fields unchanged.
- R6: For two numbers, the result exponent is the larger exponent; the smaller operand is shifted right by the difference, and its shifted-out bits together with its sticky input set the result sticky; with equal exponents the result sticky is 0.
- R7: An exponent difference of at least the mantissa width (114 by default) reduces the smaller operand to zero and sets sticky when its mantissa was nonzero.
- R8: Same-sign numbers add with x's sign; a sum of 2.0 or more (mantissa bit 113 set) is shifted right once, with the lost bit folded into sticky and the exponent incremented.
- R9: Numbers of different sign give x minus y, where the aligned sticky bit acts as an incoming borrow.
- R10: An exact cancellation gives class zero with exponent 0, mantissa 0 and sticky 0; its sign is 1 only when `rnd_mode` is 2'b11.
- R11: A difference that wraps below zero (bit 113 set) is two's-complement negated and takes y's sign; this happens only with equal exponents.
- R12: A numeric result whose integer bit (bit 112) is clear is shifted left one bit per clock, with the exponent decremented per shift. `done` rises one clock after `start` when no shift is needed and k clocks later when k shifts are needed, and a numeric result then always has bit 112 set and bit 113 clear.
- R13: A `start` while a normalization is in progress is ignored: no extra `done` and no change to the held result.
- R14: After reset, `done` and both flags are 0 and every result field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation on the present operands |
| rnd_mode | input | 2 | Rounding mode, 2'b11 = toward minus infinity |
| a_cls | input | 3 | Class code of operand A |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Signed unbiased exponent of A |
| a_mant | input | FRAC_W+2 | Mantissa of A (guard, integer, fraction) |
| a_sticky | input | 1 | Sticky bit of A |
| b_cls | input | 3 | Class code of operand B |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Signed unbiased exponent of B |
| b_mant | input | FRAC_W+2 | Mantissa of B |
| b_sticky | input | 1 | Sticky bit of B |
| done | output | 1 | One-clock pulse when the result is final |
| res_cls | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent |
| res_mant | output | FRAC_W+2 | Result mantissa |
| res_sticky | output | 1 | Result sticky bit |
| inv_snan | output | 1 | Invalid: signalling NaN operand |
| inv_inf | output | 1 | Invalid: opposite infinities added |

## Verification
On every cycle, the assertions check that a finished numeric result is normalized, that each invalid flag comes with the matching NaN result, that the normalizer never holds a zero or already-normal value while busy, that a borrow-wrap only occurs with equal exponents, and that a start during normalization leaves the result untouched. Only the bench scenarios can show the actual arithmetic values. These cover the class-ranking outcomes, the zero-sign rules under each rounding mode, the sticky produced by alignment and saturation, the exact normalization count with its latency, and the ignored start in the middle of a long normalization.

// File: rtl/fadd_pkg.sv
// Shared definitions for the unpacked adder: class codes and rounding-mode
// constants. Class codes are ordered so that numeric order equals rank.
package fadd_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_cls_e;

    localparam logic [1:0] RM_DOWN = 2'b11;

    // True for either NaN class.
    function automatic logic is_nan(input logic [2:0] c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fadd_order.sv
// Operand ranker: places the operand with the higher class code in the y
// slot. Assumes class codes follow fadd_pkg, where a larger code is heavier.
// Equal classes keep their port order.
module fadd_order #(
    parameter int EXP_W = 16,
    parameter int MW    = 114
) (
    input  logic [2:0]       a_cls,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MW-1:0]    a_mant,
    input  logic             a_sticky,
    input  logic [2:0]       b_cls,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MW-1:0]    b_mant,
    input  logic             b_sticky,
    output logic [2:0]       x_cls,
    output logic             x_sign,
    output logic [EXP_W-1:0] x_exp,
    output logic [MW-1:0]    x_mant,
    output logic             x_sticky,
    output logic [2:0]       y_cls,
    output logic             y_sign,
    output logic [EXP_W-1:0] y_exp,
    output logic [MW-1:0]    y_mant,
    output logic             y_sticky
);

    logic swap;
    assign swap = (a_cls > b_cls);

    // Route operands to x (lighter) and y (heavier).
    always_comb begin
        if (swap) begin
            x_cls = b_cls; x_sign = b_sign; x_exp = b_exp; x_mant = b_mant; x_sticky = b_sticky;
            y_cls = a_cls; y_sign = a_sign; y_exp = a_exp; y_mant = a_mant; y_sticky = a_sticky;
        end else begin
            x_cls = a_cls; x_sign = a_sign; x_exp = a_exp; x_mant = a_mant; x_sticky = a_sticky;
            y_cls = b_cls; y_sign = b_sign; y_exp = b_exp; y_mant = b_mant; y_sticky = b_sticky;
        end
    end

endmodule

// File: rtl/fadd_arith.sv
// Numeric datapath: aligns two finite numbers with a saturating right shift,
// then adds (same sign) or subtracts x-y (different sign) without a prior
// magnitude compare. A wrapped difference is negated and given y's sign.
// Assumes both mantissas have the guard bit clear.
module fadd_arith #(
    parameter int EXP_W = 16,
    parameter int MW    = 114
) (
    input  logic             x_sign,
    input  logic [EXP_W-1:0] x_exp,
    input  logic [MW-1:0]    x_mant,
    input  logic             x_sticky,
    input  logic             y_sign,
    input  logic [EXP_W-1:0] y_exp,
    input  logic [MW-1:0]    y_mant,
    input  logic             y_sticky,
    output logic             r_sign,
    output logic [EXP_W-1:0] r_exp,
    output logic [MW-1:0]    r_mant,
    output logic             r_sticky,
    output logic             r_sub,
    output logic             r_zero,
    output logic             r_uflow,
    output logic             r_eqexp
);

    localparam int ED_W  = EXP_W + 1;
    localparam int GRD_B = MW - 1;

    logic             swp, sat, lost, sh_sticky;
    logic             p_sign, q_sign, q_sticky;
    logic [EXP_W-1:0] p_exp, q_exp;
    logic [MW-1:0]    p_mant, q_mant, q_al, sum, dif;
    logic [ED_W-1:0]  ediff;

    // Put the larger exponent in p; the other operand q gets shifted.
    always_comb begin
        swp      = $signed(x_exp) < $signed(y_exp);
        p_sign   = swp ? y_sign : x_sign;
        p_exp    = swp ? y_exp  : x_exp;
        p_mant   = swp ? y_mant : x_mant;
        q_sign   = swp ? x_sign : y_sign;
        q_exp    = swp ? x_exp  : y_exp;
        q_mant   = swp ? x_mant : y_mant;
        q_sticky = swp ? x_sticky : y_sticky;
    end

    // Saturating alignment shift with sticky collection.
    always_comb begin
        ediff = {p_exp[EXP_W-1], p_exp} - {q_exp[EXP_W-1], q_exp};
        sat   = ediff >= ED_W'(MW);
        if (sat) begin
            q_al = '0;
            lost = |q_mant;
        end else begin
            q_al = q_mant >> ediff;
            lost = |(q_mant & ~({MW{1'b1}} << ediff));
        end
        sh_sticky = (ediff == '0) ? 1'b0 : (lost | q_sticky);
        r_eqexp   = (ediff == '0);
    end

    // Add or subtract, then fix carry-out or a wrapped difference.
    always_comb begin
        r_sub    = (p_sign != q_sign);
        sum      = p_mant + q_al;
        dif      = p_mant - q_al - MW'(sh_sticky);
        r_uflow  = dif[GRD_B];
        r_zero   = (dif == '0);
        r_exp    = p_exp;
        r_sticky = sh_sticky;
        r_sign   = p_sign;
        if (!r_sub) begin
            r_mant = sum;
            if (sum[GRD_B]) begin
                r_mant   = sum >> 1;
                r_sticky = sh_sticky | sum[0];
                r_exp    = p_exp + EXP_W'(1);
            end
        end else if (r_uflow) begin
            r_mant = -dif;
            r_sign = q_sign;
        end else begin
            r_mant = dif;
        end
    end

endmodule

// File: rtl/fadd_norm.sv
// Result mantissa/exponent register with an iterative left normalizer that
// moves one bit per clock. Assumes the loaded value is nonzero with the guard
// bit clear whenever ld_norm is set. fin pulses once the value is final.
module fadd_norm #(
    parameter int EXP_W = 16,
    parameter int MW    = 114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ld_norm,
    input  logic [MW-1:0]    ld_mant,
    input  logic [EXP_W-1:0] ld_exp,
    output logic [MW-1:0]    mant_q,
    output logic [EXP_W-1:0] exp_q,
    output logic             busy,
    output logic             fin
);

    localparam int INT_B = MW - 2;

    // Load a new value or take one normalization step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant_q <= '0;
            exp_q  <= '0;
            busy   <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                mant_q <= ld_mant;
                exp_q  <= ld_exp;
                busy   <= ld_norm;
                fin    <= !ld_norm;
            end else if (busy) begin
                mant_q <= mant_q << 1;
                exp_q  <= exp_q - EXP_W'(1);
                if (mant_q[INT_B-1]) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    // R12
    norm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mant_q != '0) && !mant_q[INT_B] && !mant_q[MW-1]);

endmodule

// File: rtl/fadd_core.sv
// Unpacked floating-point adder top. Ranks operands by class, resolves the
// special classes in fixed order (NaN, infinity, double zero, single zero),
// otherwise adds aligned numbers and normalizes. Assumes normal inputs have
// the integer bit set and the guard bit clear. start is ignored while busy.
module fadd_core import fadd_pkg::*; #(
    parameter int FRAC_W = 112,
    parameter int EXP_W  = 16,
    localparam int MW    = FRAC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       rnd_mode,
    input  logic [2:0]       a_cls,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MW-1:0]    a_mant,
    input  logic             a_sticky,
    input  logic [2:0]       b_cls,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MW-1:0]    b_mant,
    input  logic             b_sticky,
    output logic             done,
    output logic [2:0]       res_cls,
    output logic             res_sign,
    output logic [EXP_W-1:0] res_exp,
    output logic [MW-1:0]    res_mant,
    output logic             res_sticky,
    output logic             inv_snan,
    output logic             inv_inf
);

    localparam int INT_B = FRAC_W;
    localparam int GRD_B = FRAC_W + 1;

    logic [2:0]       x_cls, y_cls;
    logic             x_sign, y_sign, x_sticky, y_sticky;
    logic [EXP_W-1:0] x_exp, y_exp;
    logic [MW-1:0]    x_mant, y_mant;

    logic             r_sign, r_sticky, r_sub, r_zero, r_uflow, r_eqexp;
    logic [EXP_W-1:0] r_exp;
    logic [MW-1:0]    r_mant;

    logic [2:0]       n_cls;
    logic             n_sign, n_sticky, n_snan, n_inf, n_norm;
    logic [EXP_W-1:0] n_exp;
    logic [MW-1:0]    n_mant;

    logic             busy, accept, is_arith;
    logic [2:0]       cls_q;
    logic             sign_q, sticky_q, snan_q, inf_q;

    fadd_order #(.EXP_W(EXP_W), .MW(MW)) i_order (
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant), .a_sticky(a_sticky),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant), .b_sticky(b_sticky),
        .x_cls(x_cls), .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant), .x_sticky(x_sticky),
        .y_cls(y_cls), .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant), .y_sticky(y_sticky)
    );

    fadd_arith #(.EXP_W(EXP_W), .MW(MW)) i_arith (
        .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant), .x_sticky(x_sticky),
        .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant), .y_sticky(y_sticky),
        .r_sign(r_sign), .r_exp(r_exp), .r_mant(r_mant), .r_sticky(r_sticky),
        .r_sub(r_sub), .r_zero(r_zero), .r_uflow(r_uflow), .r_eqexp(r_eqexp)
    );

    // Select the result by special-case priority.
    always_comb begin
        n_cls    = y_cls;
        n_sign   = y_sign;
        n_exp    = y_exp;
        n_mant   = y_mant;
        n_sticky = y_sticky;
        n_snan   = 1'b0;
        n_inf    = 1'b0;
        n_norm   = 1'b0;
        is_arith = 1'b0;
        if (is_nan(y_cls)) begin
            n_snan = (y_cls == CLS_SNAN);
        end else if (y_cls == CLS_INF) begin
            if (x_cls == CLS_INF && x_sign != y_sign) begin
                n_cls    = CLS_QNAN;
                n_sign   = 1'b0;
                n_exp    = '0;
                n_mant   = '0;
                n_sticky = 1'b0;
                n_inf    = 1'b1;
            end
        end else if (y_cls == CLS_ZERO) begin
            n_sign = (rnd_mode == RM_DOWN) ? (x_sign | y_sign) : (x_sign & y_sign);
        end else if (x_cls == CLS_ZERO) begin
            n_cls = y_cls;
        end else if (r_sub && r_zero) begin
            is_arith = 1'b1;
            n_cls    = CLS_ZERO;
            n_sign   = (rnd_mode == RM_DOWN);
            n_exp    = '0;
            n_mant   = '0;
            n_sticky = 1'b0;
        end else begin
            is_arith = 1'b1;
            n_cls    = CLS_NUM;
            n_sign   = r_sign;
            n_exp    = r_exp;
            n_mant   = r_mant;
            n_sticky = r_sticky;
            n_norm   = !r_mant[INT_B];
        end
    end

    assign accept = start && !busy;

    // Hold class, sign, sticky and flags of the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q    <= CLS_ZERO;
            sign_q   <= 1'b0;
            sticky_q <= 1'b0;
            snan_q   <= 1'b0;
            inf_q    <= 1'b0;
        end else if (accept) begin
            cls_q    <= n_cls;
            sign_q   <= n_sign;
            sticky_q <= n_sticky;
            snan_q   <= n_snan;
            inf_q    <= n_inf;
        end
    end

    fadd_norm #(.EXP_W(EXP_W), .MW(MW)) i_norm (
        .clk(clk), .rst_n(rst_n), .load(accept), .ld_norm(n_norm),
        .ld_mant(n_mant), .ld_exp(n_exp),
        .mant_q(res_mant), .exp_q(res_exp), .busy(busy), .fin(done)
    );

    assign res_cls    = cls_q;
    assign res_sign   = sign_q;
    assign res_sticky = sticky_q;
    assign inv_snan   = snan_q;
    assign inv_inf    = inf_q;

    // R2
    snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inv_snan) |-> (res_cls == CLS_SNAN) && !inv_inf);

    // R3
    inf_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inv_inf) |-> (res_cls == CLS_QNAN) && !res_sign && (res_mant == '0));

    // R12
    norm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_cls == CLS_NUM) |-> res_mant[INT_B] && !res_mant[GRD_B]);

    // R11
    uflow_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_arith && r_sub && r_uflow) |-> r_eqexp);

    // R13
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(res_cls) && $stable(res_sign) && !done);

endmodule

// File: tb/test_fadd_core.sv
// Scoreboard bench: run_op pushes expected items, the monitor pops them on done.
module test_fadd_core;

    localparam int CLK_P = 10;
    localparam int FW    = 112;
    localparam int EW    = 16;
    localparam int MW    = FW + 2;

    localparam logic [2:0] C_ZERO = 3'd0, C_NUM = 3'd1, C_INF = 3'd2,
                           C_QNAN = 3'd3, C_SNAN = 3'd4;
    localparam logic [MW-1:0] ONE  = MW'(1) << FW;
    localparam logic [MW-1:0] HALF = ONE >> 1;
    localparam logic [MW-1:0] LSB  = MW'(1);

    typedef struct packed {
        logic [2:0]    cls;
        logic          sign;
        logic [EW-1:0] exp;
        logic [MW-1:0] mant;
        logic          sticky;
    } opnd_t;

    typedef struct packed {
        opnd_t       r;
        logic        snan;
        logic        inf;
        logic [31:0] lat;
    } item_t;

    localparam int IW = $bits(opnd_t) + 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] rmode = 2'b00;
    opnd_t va = '0, vb = '0;

    logic          done, res_sign, res_sticky, inv_snan, inv_inf;
    logic [2:0]    res_cls;
    logic [EW-1:0] res_exp;
    logic [MW-1:0] res_mant;

    item_t sb_q[$];
    string tag_q[$];
    int n_chk = 0, n_bad = 0, cyc = 0, start_cyc = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    fadd_core #(.FRAC_W(FW), .EXP_W(EW)) i_fadd_core (
        .clk(clk), .rst_n(rst_n), .start(start), .rnd_mode(rmode),
        .a_cls(va.cls), .a_sign(va.sign), .a_exp(va.exp), .a_mant(va.mant), .a_sticky(va.sticky),
        .b_cls(vb.cls), .b_sign(vb.sign), .b_exp(vb.exp), .b_mant(vb.mant), .b_sticky(vb.sticky),
        .done(done), .res_cls(res_cls), .res_sign(res_sign), .res_exp(res_exp),
        .res_mant(res_mant), .res_sticky(res_sticky), .inv_snan(inv_snan), .inv_inf(inv_inf)
    );

    function automatic opnd_t mk(input logic [2:0] c, input logic s, input logic [EW-1:0] e,
                                 input logic [MW-1:0] m, input logic st);
        mk = {c, s, e, m, st};
    endfunction

    task automatic chk(input string what, input logic [IW-1:0] act, input logic [IW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Monitor: compare each done against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk("R13 unexpected done", IW'(1), IW'(0));
            end else begin
                item_t e;
                string t;
                opnd_t got;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                got = {res_cls, res_sign, res_exp, res_mant, res_sticky};
                chk({t, " result"}, {got, inv_snan, inv_inf}, {e.r, e.snan, e.inf});
                chk({t, " latency"}, IW'(32'(cyc - start_cyc)), IW'(e.lat));
            end
        end
    end

    // Driver: apply one operation, optionally inject a start mid-run.
    task automatic run_op(input string tag, input opnd_t a, input opnd_t b, input logic [1:0] rm,
                          input opnd_t er, input logic es, input logic ei,
                          input int lat, input int inject_at);
        item_t it;
        @(negedge clk);
        va = a; vb = b; rmode = rm; start = 1'b1; start_cyc = cyc;
        it.r = er; it.snan = es; it.inf = ei; it.lat = 32'(lat);
        sb_q.push_back(it);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (inject_at > 0) begin
            repeat (inject_at) @(negedge clk);
            va = mk(C_INF, 1'b0, '0, ONE, 1'b0);
            vb = mk(C_INF, 1'b1, '0, ONE, 1'b0);
            rmode = 2'b11;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        chk("R12 watchdog expired (1=timeout)", IW'(1), IW'(0));
        summary();
        $finish;
    end

    initial begin
        opnd_t z0, z1, qn, sn, pinf, ninf;
        z0   = mk(C_ZERO, 1'b0, '0, '0, 1'b0);
        z1   = mk(C_ZERO, 1'b1, '0, '0, 1'b0);
        qn   = mk(C_QNAN, 1'b0, 16'd0, ONE | MW'(3), 1'b0);
        sn   = mk(C_SNAN, 1'b1, 16'd0, ONE | MW'(7), 1'b0);
        pinf = mk(C_INF, 1'b0, '0, ONE, 1'b0);
        ninf = mk(C_INF, 1'b1, '0, ONE, 1'b0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk("R14 reset outputs", {res_cls, res_sign, res_exp, res_mant, res_sticky, inv_snan, inv_inf}, '0);
        chk("R14 reset done", IW'(done), IW'(0));

        // R1 R2: NaN ranking in both port orders
        run_op("R1 qnan+snan", qn, sn, 2'b00, sn, 1'b1, 1'b0, 1, 0);
        run_op("R1 snan+qnan", sn, qn, 2'b00, sn, 1'b1, 1'b0, 1, 0);
        run_op("R2 snan+num", sn, mk(C_NUM, 1'b0, 16'd5, ONE, 1'b0), 2'b00, sn, 1'b1, 1'b0, 1, 0);
        run_op("R2 qnan+inf", mk(C_QNAN, 1'b1, 16'd5, ONE | MW'(2), 1'b0), pinf, 2'b00,
               mk(C_QNAN, 1'b1, 16'd5, ONE | MW'(2), 1'b0), 1'b0, 1'b0, 1, 0);

        // R3 infinities
        run_op("R3 inf-inf", pinf, ninf, 2'b00, mk(C_QNAN, 1'b0, '0, '0, 1'b0), 1'b0, 1'b1, 1, 0);
        run_op("R3 ninf+num", ninf, mk(C_NUM, 1'b0, 16'd5, ONE, 1'b0), 2'b00, ninf, 1'b0, 1'b0, 1, 0);
        run_op("R3 inf+inf", pinf, pinf, 2'b10, pinf, 1'b0, 1'b0, 1, 0);

        // R4 double zero sign rule
        run_op("R4 +0-0 nearest", z0, z1, 2'b00, z0, 1'b0, 1'b0, 1, 0);
        run_op("R4 +0-0 down", z0, z1, 2'b11, z1, 1'b0, 1'b0, 1, 0);
        run_op("R4 -0-0 zero-mode", z1, z1, 2'b01, z1, 1'b0, 1'b0, 1, 0);
        run_op("R4 +0+0 down", z0, z0, 2'b11, z0, 1'b0, 1'b0, 1, 0);

        // R5 single zero
        run_op("R5 0+num", z0, mk(C_NUM, 1'b1, 16'd7, ONE | MW'(5), 1'b1), 2'b11,
               mk(C_NUM, 1'b1, 16'd7, ONE | MW'(5), 1'b1), 1'b0, 1'b0, 1, 0);
        run_op("R5 num+0", mk(C_NUM, 1'b0, 16'hFFFD, ONE | MW'(9), 1'b0), z1, 2'b00,
               mk(C_NUM, 1'b0, 16'hFFFD, ONE | MW'(9), 1'b0), 1'b0, 1'b0, 1, 0);

        // R8 R6: equal exponents, carry out, input stickies dropped
        run_op("R8 carry R6 eq-exp", mk(C_NUM, 1'b0, 16'd3, ONE, 1'b1), mk(C_NUM, 1'b0, 16'd3, ONE, 1'b1),
               2'b00, mk(C_NUM, 1'b0, 16'd4, ONE, 1'b0), 1'b0, 1'b0, 1, 0);
        // R6 alignment by 3 with a lost bit
        run_op("R6 align sticky", mk(C_NUM, 1'b0, 16'd2, ONE | LSB, 1'b0), mk(C_NUM, 1'b0, 16'd5, ONE + HALF, 1'b0),
               2'b00, mk(C_NUM, 1'b0, 16'd5, ONE + HALF + (ONE >> 3), 1'b1), 1'b0, 1'b0, 1, 0);
        // R7 saturated shift
        run_op("R7 saturate", mk(C_NUM, 1'b0, 16'd0, ONE, 1'b0), mk(C_NUM, 1'b0, 16'd200, ONE, 1'b0),
               2'b00, mk(C_NUM, 1'b0, 16'd200, ONE, 1'b1), 1'b0, 1'b0, 1, 0);
        // R9 borrow from sticky, two normalization steps
        run_op("R9 borrow", mk(C_NUM, 1'b0, 16'd1, ONE, 1'b0), mk(C_NUM, 1'b1, 16'd0, ONE | LSB, 1'b0),
               2'b00, mk(C_NUM, 1'b0, 16'hFFFF, (HALF - LSB) << 2, 1'b1), 1'b0, 1'b0, 3, 0);
        // R10 exact cancellation
        run_op("R10 cancel nearest", mk(C_NUM, 1'b0, 16'd3, ONE + MW'(5), 1'b0),
               mk(C_NUM, 1'b1, 16'd3, ONE + MW'(5), 1'b0), 2'b00, z0, 1'b0, 1'b0, 1, 0);
        run_op("R10 cancel down", mk(C_NUM, 1'b0, 16'd3, ONE + MW'(5), 1'b0),
               mk(C_NUM, 1'b1, 16'd3, ONE + MW'(5), 1'b0), 2'b11, z1, 1'b0, 1'b0, 1, 0);
        // R11 wrapped difference
        run_op("R11 negate", mk(C_NUM, 1'b0, 16'd4, ONE, 1'b0), mk(C_NUM, 1'b1, 16'd4, ONE + HALF, 1'b0),
               2'b00, mk(C_NUM, 1'b1, 16'd3, ONE, 1'b0), 1'b0, 1'b0, 2, 0);
        // R12 R13: 112-step normalization with an ignored start in the middle
        run_op("R12 deep norm", mk(C_NUM, 1'b0, 16'd10, ONE, 1'b0), mk(C_NUM, 1'b1, 16'd10, ONE | LSB, 1'b0),
               2'b00, mk(C_NUM, 1'b1, 16'hFF9A, ONE, 1'b0), 1'b0, 1'b0, 113, 20);

        repeat (8) @(negedge clk);
        // R13 no late done and the held result unchanged after the ignored start
        chk("R13 held result", {res_cls, res_sign, res_exp, res_mant, res_sticky, inv_snan, inv_inf},
            {mk(C_NUM, 1'b1, 16'hFF9A, ONE, 1'b0), 1'b0, 1'b0});
        chk("R13 done quiet", IW'(done), IW'(0));

        summary();
        $finish;
    end

endmodule